// File: doc/BRIEF.md
# Split-Transaction Packet Bus Arbiter

This block decides which of several devices drives a shared, split-transaction packet bus. Each device owns a fixed device ID equal to its bit position. A device can ask for the bus in two classes: for a reply packet (answering an earlier transaction) or for a request packet (starting a new one). A one-cycle pulse on a class line adds one pending ask for that device and class. A device may pile up several asks in each class, and the two classes are counted apart, so a reply and a request from one device never merge. The two halves of one transaction arbitrate on their own, with any delay between them.

Packets are short (2 cycles) or long (9 cycles), and the first cycle is the header. While a packet is in flight the arbiter already picks the next winner, so the next packet can begin on the cycle after the last cycle of the current one. Replies always beat requests, which throttles new traffic while answers are owed. Inside a class, a rotating pointer gives fairness. Once granted, a packet runs to its end and is never cut short. The grant is a one-hot vector plus the winner's ID, a class flag and a header strobe. The stream here is the packet itself, and the bus has no back-pressure: a granted device must send on every cycle of its grant. The ask pulses are plain control pins and need no handshake.

Top module: `pkt_bus_arbiter`

## Requirements
- R1: After reset, no grant is active, `hdr` is low, `gnt_rply` is low and all pending counts are zero.
- R2: `grant` is one-hot or zero. A packet holds the same grant for exactly 2 cycles when the winner's length bit for the winning class (`rq_long` or `rp_long`, 1 = long) is 0 at the decision edge, and for exactly 9 cycles when it is 1.
- R3: No grant changes before the current packet's last cycle, whatever arrives in the meantime.
- R4: `hdr` is high exactly in the first cycle of each packet. When no device is granted the bus is idle and `hdr` is low.
- R5: If any reply ask is pending when a decision is made, a reply packet wins over every pending request ask.
- R6: Within a class, the search starts at the ID after the last device granted in that class and wraps around. The first search after reset starts at ID 0.
- R7: If anything is pending in the last cycle of a packet (or in an idle cycle), a new packet starts in the very next cycle, with no gap.
- R8: Each device keeps a pending count per class, from 0 to 2^CNT_W-1. A pulse adds one and a grant removes one. A pulse in the same cycle as that count's grant leaves the count unchanged. A pulse that finds the count full, with no grant for it in that cycle, is ignored.
- R9: `gnt_rply` is 1 for a reply packet and 0 for a request packet, and `grant_id` gives the winner's ID, for the whole packet.
- R10: A pulse on `rq_pulse` or `rp_pulse` is counted first, then becomes visible to arbitration one cycle later. A packet for it can start at the earliest two cycles after the pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rq_pulse | input | N_DEV | One pending request-class ask per set bit |
| rp_pulse | input | N_DEV | One pending reply-class ask per set bit |
| rq_long | input | N_DEV | Length of the device's request packet (1 = 9 cycles, 0 = 2) |
| rp_long | input | N_DEV | Length of the device's reply packet (1 = 9 cycles, 0 = 2) |
| grant | output | N_DEV | One-hot bus ownership, zero when idle |
| grant_id | output | $clog2(N_DEV) | ID of the current owner |
| gnt_rply | output | 1 | Current packet is a reply |
| hdr | output | 1 | First (header) cycle of a packet |

## Verification
Several properties are checked on every cycle:
- the grant stays one-hot;
- the header only appears under a grant;
- no packet is pre-empted;
- each packet lasts 2 or 9 cycles;
- a pending ask at a packet's end always yields a header on the next cycle;
- a decision made while a reply was pending is a reply.

Some behaviours can only be shown by the bench's scenarios, which compare every cycle against an independent model:
- round-robin order within a class;
- correct length selection per class;
- the pulse-to-grant latency;
- pending counts that saturate and later drain exactly the number of packets they held.

// File: rtl/pba_pkg.sv
package pba_pkg;
  localparam int SHORT_LEN = 2;
  localparam int LONG_LEN  = 9;
  localparam int LEN_W     = $clog2(LONG_LEN);

  typedef enum logic {
    CLS_REQ = 1'b0,
    CLS_RPL = 1'b1
  } pkt_cls_e;
endpackage

// File: rtl/pba_pend_bank.sv
// Per-device pending counters for one priority class.
module pba_pend_bank #(
  parameter int N_DEV = 4,
  parameter int CNT_W = 3,
  localparam int IDW  = $clog2(N_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] pulse,
  input  logic             take,
  input  logic [IDW-1:0]   take_id,
  output logic [N_DEV-1:0] nonzero
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  genvar g;
  generate
    for (g = 0; g < N_DEV; g++) begin : g_dev
      logic [CNT_W-1:0] cnt;
      logic             dec;
      logic             inc;

      assign dec = take && (take_id == IDW'(g));
      assign inc = pulse[g];

      // R8: add on pulse, remove on grant, hold when both, drop a pulse when full
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          cnt <= '0;
        end else if (inc && !dec && cnt != CNT_MAX) begin
          cnt <= cnt + 1'b1;
        end else if (!inc && dec) begin
          cnt <= cnt - 1'b1;
        end
      end

      assign nonzero[g] = (cnt != '0);
    end
  endgenerate
endmodule

// File: rtl/pba_rr_pick.sv
// Rotating search: first set bit strictly after ptr, wrapping around.
module pba_rr_pick #(
  parameter int N_DEV = 4,
  localparam int IDW  = $clog2(N_DEV)
) (
  input  logic [N_DEV-1:0] req,
  input  logic [IDW-1:0]   ptr,
  output logic             found,
  output logic [IDW-1:0]   sel
);
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int off = 1; off <= N_DEV; off++) begin
      int idx;
      idx = (int'(ptr) + off) % N_DEV;
      if (!found && req[idx]) begin
        found = 1'b1;
        sel   = IDW'(idx);
      end
    end
  end
endmodule

// File: rtl/pba_pkt_seq.sv
// Packet sequencer: holds the grant for a full packet and launches the next
// winner on the edge that closes the current packet.
module pba_pkt_seq
  import pba_pkg::*;
#(
  parameter int N_DEV = 4,
  localparam int IDW  = $clog2(N_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rq_found,
  input  logic [IDW-1:0]   rq_sel,
  input  logic             rp_found,
  input  logic [IDW-1:0]   rp_sel,
  input  logic [N_DEV-1:0] rq_long,
  input  logic [N_DEV-1:0] rp_long,
  output logic [IDW-1:0]   rq_ptr,
  output logic [IDW-1:0]   rp_ptr,
  output logic             take_rq,
  output logic             take_rp,
  output logic [IDW-1:0]   take_id,
  output logic             pkt_last,
  output logic             busy,
  output logic [IDW-1:0]   cur_id,
  output pkt_cls_e         cur_cls,
  output logic             hdr
);
  logic [LEN_W-1:0] rem;
  logic             launch;
  pkt_cls_e         win_cls;
  logic [IDW-1:0]   win_id;
  logic             win_long;
  logic [LEN_W-1:0] win_rem;

  // R7: decision is ready during the packet's last cycle
  assign pkt_last = !busy || (rem == '0);
  assign launch   = pkt_last && (rp_found || rq_found);

  // R5: reply class beats request class
  assign win_cls  = rp_found ? CLS_RPL : CLS_REQ;
  assign win_id   = rp_found ? rp_sel : rq_sel;
  assign win_long = rp_found ? rp_long[win_id] : rq_long[win_id];
  assign win_rem  = win_long ? LEN_W'(LONG_LEN - 1) : LEN_W'(SHORT_LEN - 1);

  assign take_rq = launch && (win_cls == CLS_REQ);
  assign take_rp = launch && (win_cls == CLS_RPL);
  assign take_id = win_id;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      rem     <= '0;
      cur_id  <= '0;
      cur_cls <= CLS_REQ;
      hdr     <= 1'b0;
    end else if (launch) begin
      busy    <= 1'b1;
      rem     <= win_rem;
      cur_id  <= win_id;
      cur_cls <= win_cls;
      hdr     <= 1'b1;
    end else if (pkt_last) begin
      busy    <= 1'b0;
      hdr     <= 1'b0;
    end else begin
      rem     <= rem - 1'b1;
      hdr     <= 1'b0;
    end
  end

  // R6: per-class pointer remembers the last device served in that class
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rq_ptr <= IDW'(N_DEV - 1);
      rp_ptr <= IDW'(N_DEV - 1);
    end else begin
      if (take_rq) rq_ptr <= win_id;
      if (take_rp) rp_ptr <= win_id;
    end
  end
endmodule

// File: rtl/pkt_bus_arbiter.sv
module pkt_bus_arbiter
  import pba_pkg::*;
#(
  parameter int N_DEV = 4,
  parameter int CNT_W = 3,
  localparam int IDW  = $clog2(N_DEV)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_DEV-1:0] rq_pulse,
  input  logic [N_DEV-1:0] rp_pulse,
  input  logic [N_DEV-1:0] rq_long,
  input  logic [N_DEV-1:0] rp_long,
  output logic [N_DEV-1:0] grant,
  output logic [IDW-1:0]   grant_id,
  output logic             gnt_rply,
  output logic             hdr
);
  logic [N_DEV-1:0] rq_pend, rp_pend;
  logic             rq_found, rp_found;
  logic [IDW-1:0]   rq_sel, rp_sel, rq_ptr, rp_ptr;
  logic             take_rq, take_rp;
  logic [IDW-1:0]   take_id;
  logic             seq_last, busy;
  logic [IDW-1:0]   cur_id;
  pkt_cls_e         cur_cls;
  logic             rq_any, rp_any;

  pba_pend_bank #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_rq_bank (
    .clk(clk), .rst_n(rst_n), .pulse(rq_pulse),
    .take(take_rq), .take_id(take_id), .nonzero(rq_pend));

  pba_pend_bank #(.N_DEV(N_DEV), .CNT_W(CNT_W)) u_rp_bank (
    .clk(clk), .rst_n(rst_n), .pulse(rp_pulse),
    .take(take_rp), .take_id(take_id), .nonzero(rp_pend));

  pba_rr_pick #(.N_DEV(N_DEV)) u_rq_pick (
    .req(rq_pend), .ptr(rq_ptr), .found(rq_found), .sel(rq_sel));

  pba_rr_pick #(.N_DEV(N_DEV)) u_rp_pick (
    .req(rp_pend), .ptr(rp_ptr), .found(rp_found), .sel(rp_sel));

  pba_pkt_seq #(.N_DEV(N_DEV)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .rq_found(rq_found), .rq_sel(rq_sel),
    .rp_found(rp_found), .rp_sel(rp_sel),
    .rq_long(rq_long), .rp_long(rp_long),
    .rq_ptr(rq_ptr), .rp_ptr(rp_ptr),
    .take_rq(take_rq), .take_rp(take_rp), .take_id(take_id),
    .pkt_last(seq_last), .busy(busy),
    .cur_id(cur_id), .cur_cls(cur_cls), .hdr(hdr));

  assign rq_any = |rq_pend;
  assign rp_any = |rp_pend;

  // R2 / R9: outputs derived from the held packet state
  assign grant    = busy ? ({{(N_DEV-1){1'b0}}, 1'b1} << cur_id) : '0;
  assign grant_id = cur_id;
  assign gnt_rply = busy && (cur_cls == CLS_RPL);
endmodule

// File: rtl/pba_chk.sv
module pba_chk #(
  parameter int N_DEV = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic [N_DEV-1:0] grant,
  input logic             hdr,
  input logic             gnt_rply,
  input logic             pkt_last,
  input logic             any_pend,
  input logic             any_rp
);
  logic [4:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)      run <= '0;
    else if (hdr)    run <= 5'd1;
    else if (|grant) run <= run + 5'd1;
    else             run <= '0;
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  assert_pkt_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hdr || !(|grant)) && run != 5'd0) |-> (run == 5'd2 || run == 5'd9));

  assert_no_preempt_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (|grant && !hdr) |-> (grant == $past(grant)));

  assert_hdr_needs_grant_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr |-> (|grant));

  assert_reply_first_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_last && any_rp) |=> (hdr && gnt_rply));

  assert_zero_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_last && any_pend) |=> hdr);
endmodule

bind pkt_bus_arbiter pba_chk #(.N_DEV(N_DEV)) u_pba_chk (
  .clk(clk), .rst_n(rst_n), .grant(grant), .hdr(hdr), .gnt_rply(gnt_rply),
  .pkt_last(seq_last), .any_pend(rq_any | rp_any), .any_rp(rp_any));

// File: tb/pkt_bus_arbiter_tb.sv
module pkt_bus_arbiter_tb_top;
  localparam int N   = 4;
  localparam int CW  = 3;
  localparam int MAXC = (1 << CW) - 1;
  localparam int IDW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] rq_pulse = '0, rp_pulse = '0, rq_long = '0, rp_long = '0;
  logic [N-1:0] grant;
  logic [IDW-1:0] grant_id;
  logic gnt_rply, hdr;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  string tag  = "R1";

  // model state
  int  m_cnt [2][N];
  int  m_ptr [2];
  bit  m_busy, m_rply, m_hdr;
  int  m_id, m_rem;
  int  hdr_seen;

  always #5 clk = ~clk;

  pkt_bus_arbiter #(.N_DEV(N), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .rq_pulse(rq_pulse), .rp_pulse(rp_pulse),
    .rq_long(rq_long), .rp_long(rp_long), .grant(grant), .grant_id(grant_id),
    .gnt_rply(gnt_rply), .hdr(hdr));

  task automatic chk(string what, int got, int exp);
    n_tests++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s %s got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int pick(int cls);
    for (int off = 1; off <= N; off++) begin
      int idx = (m_ptr[cls] + off) % N;
      if (m_cnt[cls][idx] > 0) return idx;
    end
    return -1;
  endfunction

  task automatic model_reset();
    for (int c = 0; c < 2; c++) begin
      for (int i = 0; i < N; i++) m_cnt[c][i] = 0;
      m_ptr[c] = N - 1;
    end
    m_busy = 0; m_rply = 0; m_hdr = 0; m_id = 0; m_rem = 0;
  endtask

  // Next state from requirements, using inputs held for the coming edge.
  task automatic model_step();
    bit dec [2][N];
    for (int c = 0; c < 2; c++) for (int i = 0; i < N; i++) dec[c][i] = 0;
    if (!m_busy || m_rem == 0) begin
      int cls = (pick(1) >= 0) ? 1 : 0;  // R5
      int w   = pick(cls);               // R6
      if (w >= 0) begin
        bit lg = cls ? rp_long[w] : rq_long[w];
        m_busy = 1; m_rply = (cls == 1); m_id = w; m_hdr = 1;
        m_rem = (lg ? 9 : 2) - 1;         // R2
        m_ptr[cls] = w;
        dec[cls][w] = 1;
      end else begin
        m_busy = 0; m_hdr = 0;
      end
    end else begin
      m_rem--; m_hdr = 0;                 // R3
    end
    for (int i = 0; i < N; i++) begin     // R8, R10
      for (int c = 0; c < 2; c++) begin
        bit inc = c ? rp_pulse[i] : rq_pulse[i];
        if (inc && !dec[c][i] && m_cnt[c][i] < MAXC) m_cnt[c][i]++;
        else if (!inc && dec[c][i]) m_cnt[c][i]--;
      end
    end
  endtask

  task automatic compare();
    chk("grant", int'(grant), m_busy ? (1 << m_id) : 0);
    chk("hdr", int'(hdr), int'(m_hdr));                 // R4
    chk("gnt_rply", int'(gnt_rply), int'(m_busy && m_rply)); // R9
    if (m_busy) chk("grant_id", int'(grant_id), m_id);
    if (hdr) hdr_seen++;
  endtask

  // One cycle: check at negedge, apply inputs, advance model.
  task automatic cyc(logic [N-1:0] q, logic [N-1:0] p,
                     logic [N-1:0] ql, logic [N-1:0] pl);
    @(negedge clk);
    compare();
    rq_pulse = q; rp_pulse = p; rq_long = ql; rp_long = pl;
    model_step();
  endtask

  initial begin
    void'($urandom(32'd20240611));
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state
    tag = "R1";
    chk("reset grant", int'(grant), 0);
    chk("reset hdr", int'(hdr), 0);
    chk("reset gnt_rply", int'(gnt_rply), 0);
    rst_n = 1'b1;
    model_step();

    // R10 latency and R9 class flag: single reply ask from device 2, short
    tag = "R10";
    cyc('0, 4'b0100, '0, '0);
    cyc('0, '0, '0, '0);
    @(negedge clk);
    chk("R10 hdr two cycles after pulse", int'(hdr), 1);
    chk("R9 reply flag", int'(gnt_rply), 1);
    model_step();
    repeat (4) cyc('0, '0, '0, '0);

    // R5 and R6: all devices ask requests, two ask replies at once
    tag = "R5 R6";
    cyc(4'b1111, 4'b1010, 4'b0101, 4'b0010);
    repeat (40) cyc('0, '0, 4'b0101, 4'b0010);

    // R8: saturate device 1 request count with long packets, then drain
    tag = "R8";
    hdr_seen = 0;
    repeat (30) cyc(4'b0010, '0, 4'b0010, '0);
    repeat (90) cyc('0, '0, 4'b0010, '0);
    chk("R8 saturated count drained packets", hdr_seen, 3 + MAXC + 1);

    // R10: same device asks in both classes at once, counted apart
    tag = "R10";
    cyc(4'b1000, 4'b1000, '0, '0);
    repeat (10) cyc('0, '0, '0, '0);

    // R2 R3 R4 R6 R7: random traffic
    tag = "R2 R3 R4 R6 R7";
    for (int k = 0; k < 4000; k++) begin
      logic [N-1:0] q, p;
      for (int i = 0; i < N; i++) begin
        q[i] = ($urandom % 7) == 0;
        p[i] = ($urandom % 11) == 0;
      end
      cyc(q, p, N'($urandom), N'($urandom));
    end
    repeat (200) cyc('0, '0, '0, '0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule